// File: doc/BRIEF.md
# SPI Slave Debug Message Port

This block lets an external SPI master read a stream of debug bytes produced by on-chip logic. Internal producers push bytes into a small queue through a valid/data pair. Whenever the master selects the device and clocks a transfer, the queued bytes leave on MISO in the order they were pushed, most significant bit first. Every transfer is a whole number of 8-bit bytes. Bytes the master shifts in on MOSI are assembled and handed to the system clock domain with a one-cycle valid pulse, so that later logic can treat them as commands.

The master always owns SCK and chip select. Clock polarity and clock phase come from two static configuration inputs, which cover all four SPI modes. SCK, chip select and MOSI are passed through a two-flop synchroniser and handled entirely in the system clock domain. For this reason each SCK half-period must last at least four system clock cycles. If the queue runs dry, the port sends a zero filler byte and raises an underflow flag. A push into a full queue is dropped and recorded in a sticky overflow flag.

Top module: `spi_dbg_port`

## Requirements
- R1: After reset, q_empty_o is 1 and q_full_o, overflow_o, underflow_o, rx_valid_o and miso_oe_o are all 0.
- R2: Queued bytes appear on MISO in push order, most significant bit first. A byte counts as consumed once the master has sampled its first bit.
- R3: The mode is set by cpol_i (SCK idle level) and cpha_i. With cpha_i=0, the master samples on the edge that leaves the idle level. With cpha_i=1, it samples on the edge that returns to it. All four combinations deliver the same byte stream.
- R4: With cpha_i=0, the most significant bit of the head byte is on miso_o within four system clocks of chip select falling, before any SCK edge.
- R5: A byte slot started while the queue is empty sends 0x00, and sampling its first bit sets underflow_o. underflow_o clears when chip select next asserts.
- R6: The queue holds DEPTH (16) bytes, and q_full_o is 1 when it does. A push while full is dropped and sets overflow_o, which stays set until reset.
- R7: Each 8 MOSI bits, taken most significant bit first at the sampling edge, give rx_data_o together with a single-cycle rx_valid_o.
- R8: Releasing chip select in the middle of a byte discards the partial MOSI byte without a valid pulse and restarts the bit count, so the next transfer is byte aligned. A head byte that was presented but never sampled stays in the queue.
- R9: miso_oe_o is 1 while chip select (synchronised) is asserted and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cpol_i | input | 1 | SCK idle level (static) |
| cpha_i | input | 1 | Clock phase select (static) |
| sck_i | input | 1 | SPI clock from master |
| cs_ni | input | 1 | Active-low chip select from master |
| mosi_i | input | 1 | Serial data from master |
| miso_o | output | 1 | Serial data to master |
| miso_oe_o | output | 1 | MISO drive enable |
| msg_data_i | input | 8 | Debug byte to queue |
| msg_valid_i | input | 1 | Push strobe for msg_data_i |
| q_full_o | output | 1 | Queue holds DEPTH bytes |
| q_empty_o | output | 1 | Queue holds no bytes |
| overflow_o | output | 1 | Sticky: a push was dropped |
| underflow_o | output | 1 | Filler byte sent in this transfer |
| rx_data_o | output | 8 | Last complete MOSI byte |
| rx_valid_o | output | 1 | One-cycle strobe for rx_data_o |

## Verification
If the bit counter is wrong or misaligned, the next byte the master reads is rotated and the rx_data_o value is shifted. Both show up at the end of the first byte after the fault, and a counter that is not cleared on an abort corrupts the first byte of the following transfer. A wrong pop decision loses or repeats a queue entry, so the received sequence differs from the pushed one at the byte after the fault. The same fault also leaves q_empty_o at the wrong value once the expected number of bytes has been read. Faults in mode decoding corrupt the first bit of the first byte in the affected mode, and a wrong filler path shows as a nonzero byte or a missing underflow_o right after the empty-queue slot.

// File: rtl/spi_dbg_pkg.sv
package spi_dbg_pkg;
  localparam int unsigned BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/spi_dbg_sync.sv
module spi_dbg_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST   = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg[0] <= RST;
    else         stg[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg[s] <= RST;
      else         stg[s] <= stg[s-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/spi_dbg_fifo.sv
module spi_dbg_fifo
  import spi_dbg_pkg::*;
#(
  parameter int unsigned DEPTH = 16
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  push_i,
  input  byte_t wdata_i,
  input  logic  pop_i,
  output byte_t head_o,
  output logic  full_o,
  output logic  empty_o,
  output logic  overflow_o
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  byte_t         mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          do_push, do_pop;

  assign full_o  = (count == CW'(DEPTH));
  assign empty_o = (count == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign head_o  = mem[rd_ptr];

  function automatic logic [AW-1:0] inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wr_ptr] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr     <= '0;
      rd_ptr     <= '0;
      count      <= '0;
      overflow_o <= 1'b0;
    end else begin
      if (do_push) wr_ptr <= inc(wr_ptr);
      if (do_pop)  rd_ptr <= inc(rd_ptr);
      if (do_push && !do_pop)      count <= count + 1'b1;
      else if (do_pop && !do_push) count <= count - 1'b1;
      if (push_i && full_o) overflow_o <= 1'b1;
    end
  end
endmodule

// File: rtl/spi_dbg_engine.sv
module spi_dbg_engine
  import spi_dbg_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  cpol_i,
  input  logic  cpha_i,
  input  logic  sck_i,
  input  logic  cs_ni,
  input  logic  mosi_i,
  input  byte_t head_i,
  input  logic  head_vld_i,
  output logic  pop_o,
  output logic  miso_o,
  output logic  active_o,
  output logic  underflow_o,
  output byte_t rx_data_o,
  output logic  rx_valid_o
);
  localparam int unsigned CW = $clog2(BYTE_W);

  logic          act, act_q, sck_n, sck_n_q;
  logic          start, lead, trail, samp, shft, load;
  logic [CW-1:0] bit_cnt;
  logic          last_bit, tx_real;
  byte_t         tx_sh, rx_sh;

  // normalise SCK so a rising sck_n is always the leading edge
  assign act      = !cs_ni;
  assign sck_n    = sck_i ^ cpol_i;
  assign start    = act && !act_q;
  assign lead     = act && act_q && sck_n && !sck_n_q;
  assign trail    = act && act_q && !sck_n && sck_n_q;
  assign samp     = cpha_i ? trail : lead;
  assign shft     = cpha_i ? lead : trail;
  assign load     = start || (shft && bit_cnt == '0);
  assign last_bit = (bit_cnt == CW'(BYTE_W - 1));
  assign pop_o    = samp && bit_cnt == '0 && tx_real;
  assign miso_o   = tx_sh[BYTE_W-1];
  assign active_o = act;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q       <= 1'b0;
      sck_n_q     <= 1'b0;
      bit_cnt     <= '0;
      tx_sh       <= '0;
      tx_real     <= 1'b0;
      rx_sh       <= '0;
      rx_data_o   <= '0;
      rx_valid_o  <= 1'b0;
      underflow_o <= 1'b0;
    end else begin
      act_q      <= act;
      sck_n_q    <= sck_n;
      rx_valid_o <= 1'b0;
      if (start) underflow_o <= 1'b0;
      // head is only peeked here; consumption happens at first sample
      if (load) begin
        tx_sh   <= head_vld_i ? head_i : '0;
        tx_real <= head_vld_i;
      end else if (shft) begin
        tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
      end
      if (!act) begin
        bit_cnt <= '0;
      end else if (samp) begin
        rx_sh   <= {rx_sh[BYTE_W-2:0], mosi_i};
        bit_cnt <= last_bit ? '0 : bit_cnt + 1'b1;
        if (bit_cnt == '0 && !tx_real) underflow_o <= 1'b1;
        if (last_bit) begin
          rx_data_o  <= {rx_sh[BYTE_W-2:0], mosi_i};
          rx_valid_o <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/spi_dbg_port.sv
module spi_dbg_port
  import spi_dbg_pkg::*;
#(
  parameter int unsigned DEPTH       = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpol_i,
  input  logic              cpha_i,
  input  logic              sck_i,
  input  logic              cs_ni,
  input  logic              mosi_i,
  output logic              miso_o,
  output logic              miso_oe_o,
  input  logic [BYTE_W-1:0] msg_data_i,
  input  logic              msg_valid_i,
  output logic              q_full_o,
  output logic              q_empty_o,
  output logic              overflow_o,
  output logic              underflow_o,
  output logic [BYTE_W-1:0] rx_data_o,
  output logic              rx_valid_o
);
  logic [2:0] pins_s;
  byte_t      head;
  logic       pop;

  spi_dbg_sync #(.W(3), .STAGES(SYNC_STAGES), .RST(3'b010)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sck_i, cs_ni, mosi_i}),
    .q_o   (pins_s)
  );

  spi_dbg_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .push_i    (msg_valid_i),
    .wdata_i   (msg_data_i),
    .pop_i     (pop),
    .head_o    (head),
    .full_o    (q_full_o),
    .empty_o   (q_empty_o),
    .overflow_o(overflow_o)
  );

  spi_dbg_engine u_eng (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cpol_i     (cpol_i),
    .cpha_i     (cpha_i),
    .sck_i      (pins_s[2]),
    .cs_ni      (pins_s[1]),
    .mosi_i     (pins_s[0]),
    .head_i     (head),
    .head_vld_i (!q_empty_o),
    .pop_o      (pop),
    .miso_o     (miso_o),
    .active_o   (miso_oe_o),
    .underflow_o(underflow_o),
    .rx_data_o  (rx_data_o),
    .rx_valid_o (rx_valid_o)
  );
endmodule

// File: rtl/spi_dbg_port_chk.sv
module spi_dbg_port_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic msg_valid_i,
  input logic q_full_o,
  input logic q_empty_o,
  input logic overflow_o,
  input logic rx_valid_o,
  input logic miso_oe_o
);
  a_r7_rx_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> !rx_valid_o);

  a_r6_overflow_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |=> overflow_o);

  a_r6_overflow_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(overflow_o) |-> $past(q_full_o && msg_valid_i));

  a_r6_push_fills: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_empty_o && msg_valid_i) |=> !q_empty_o);

  a_r9_rx_needs_select: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |-> miso_oe_o);
endmodule

bind spi_dbg_port spi_dbg_port_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .msg_valid_i(msg_valid_i),
  .q_full_o   (q_full_o),
  .q_empty_o  (q_empty_o),
  .overflow_o (overflow_o),
  .rx_valid_o (rx_valid_o),
  .miso_oe_o  (miso_oe_o)
);

// File: tb/sim_spi_dbg_port.sv
`timescale 1ns/1ps
module sim_spi_dbg_port;
  localparam int HALF = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cpol = 1'b0, cpha = 1'b0;
  logic       sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic       miso, miso_oe;
  logic [7:0] msg_data = '0;
  logic       msg_valid = 1'b0;
  logic       q_full, q_empty, ovf, unf;
  logic [7:0] rx_data;
  logic       rx_valid;

  int checks = 0, errors = 0;
  logic [7:0] host_tx [32];
  logic [7:0] host_rx [32];
  logic [7:0] rx_log  [64];
  int rx_cnt = 0;

  always #10 clk = ~clk;

  spi_dbg_port u0 (
    .clk_i(clk), .rst_ni(rst_n), .cpol_i(cpol), .cpha_i(cpha),
    .sck_i(sck), .cs_ni(cs_n), .mosi_i(mosi), .miso_o(miso),
    .miso_oe_o(miso_oe), .msg_data_i(msg_data), .msg_valid_i(msg_valid),
    .q_full_o(q_full), .q_empty_o(q_empty), .overflow_o(ovf),
    .underflow_o(unf), .rx_data_o(rx_data), .rx_valid_o(rx_valid)
  );

  always @(negedge clk) if (rx_valid && rx_cnt < 64) begin
    rx_log[rx_cnt] = rx_data;
    rx_cnt++;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(input logic [7:0] d);
    @(negedge clk);
    msg_data = d; msg_valid = 1'b1;
    @(negedge clk);
    msg_valid = 1'b0;
  endtask

  task automatic set_mode(input logic pol, input logic pha);
    @(negedge clk);
    cpol = pol; cpha = pha; sck = pol;
    wait_clk(6);
  endtask

  // master model: nbits bits, host_tx out, host_rx in
  task automatic spi_run(input int nbits);
    @(negedge clk);
    cs_n = 1'b0;
    wait_clk(HALF);
    for (int i = 0; i < nbits; i++) begin
      logic b;
      b = host_tx[i/8][7-(i%8)];
      if (!cpha) mosi = b;
      wait_clk(HALF);
      if (!cpha) host_rx[i/8][7-(i%8)] = miso;
      sck = ~cpol;
      if (cpha) mosi = b;
      wait_clk(HALF);
      if (cpha) host_rx[i/8][7-(i%8)] = miso;
      sck = cpol;
    end
    wait_clk(HALF);
    cs_n = 1'b1;
    wait_clk(HALF);
  endtask

  task automatic t_reset;
    chk("R1 empty", q_empty, 1);
    chk("R1 full", q_full, 0);
    chk("R1 overflow", ovf, 0);
    chk("R1 underflow", unf, 0);
    chk("R1 rx_valid", rx_valid, 0);
    chk("R1 miso_oe", miso_oe, 0);
  endtask

  task automatic t_modes;
    for (int m = 0; m < 4; m++) begin
      logic [7:0] exp_b [3];
      int base;
      set_mode(m[1], m[0]);
      for (int k = 0; k < 3; k++) begin
        exp_b[k] = 8'(8'h96 + m * 8'h21 + k * 8'h4D);
        host_tx[k] = ~exp_b[k];
        push(exp_b[k]);
      end
      base = rx_cnt;
      spi_run(24);
      for (int k = 0; k < 3; k++) begin
        chk($sformatf("R2 R3 mode%0d byte%0d", m, k), host_rx[k], exp_b[k]);
        chk($sformatf("R7 mode%0d rx%0d", m, k), rx_log[base+k], host_tx[k]);
      end
      chk($sformatf("R7 mode%0d rx count", m), rx_cnt - base, 3);
      chk($sformatf("R2 mode%0d drained", m), q_empty, 1);
      chk($sformatf("R5 mode%0d no underflow", m), unf, 0);
    end
  endtask

  task automatic t_early_msb;
    set_mode(1'b1, 1'b0);
    push(8'h81);
    @(negedge clk); cs_n = 1'b0;
    wait_clk(4);
    chk("R4 msb before first edge", miso, 1);
    chk("R9 oe while selected", miso_oe, 1);
    wait_clk(4);
    cs_n = 1'b1;
    wait_clk(6);
    chk("R9 oe after release", miso_oe, 0);
    chk("R8 unsampled byte kept", q_empty, 0);
    host_tx[0] = 8'h00;
    spi_run(8);
    chk("R8 kept byte delivered", host_rx[0], 8'h81);
    chk("R8 queue drained", q_empty, 1);
  endtask

  task automatic t_underflow;
    set_mode(1'b0, 1'b1);
    host_tx[0] = 8'h5A;
    spi_run(8);
    chk("R5 filler byte", host_rx[0], 8'h00);
    chk("R5 underflow set", unf, 1);
    push(8'h42);
    @(negedge clk); cs_n = 1'b0;
    wait_clk(5);
    chk("R5 underflow cleared on select", unf, 0);
    cs_n = 1'b1;
    wait_clk(6);
    spi_run(8);
    chk("R5 byte after filler", host_rx[0], 8'h42);
    chk("R5 no underflow with data", unf, 0);
  endtask

  task automatic t_overflow;
    set_mode(1'b1, 1'b1);
    for (int i = 0; i < 16; i++) push(8'(i * 7 + 1));
    chk("R6 full at depth", q_full, 1);
    chk("R6 no overflow yet", ovf, 0);
    push(8'hEE);
    chk("R6 overflow set", ovf, 1);
    for (int i = 0; i < 16; i++) host_tx[i] = 8'(i);
    spi_run(128);
    for (int i = 0; i < 16; i++)
      chk($sformatf("R6 order byte%0d", i), host_rx[i], 8'(i * 7 + 1));
    chk("R6 dropped byte absent", q_empty, 1);
    chk("R6 overflow sticky", ovf, 1);
    chk("R6 not full", q_full, 0);
  endtask

  task automatic t_abort;
    int base;
    set_mode(1'b0, 1'b0);
    push(8'hA5);
    push(8'h3C);
    host_tx[0] = 8'hF0;
    base = rx_cnt;
    spi_run(3);
    chk("R8 no rx pulse on abort", rx_cnt - base, 0);
    chk("R2 R8 partial byte consumed", q_empty, 0);
    host_tx[0] = 8'h6B;
    spi_run(8);
    chk("R8 realigned tx", host_rx[0], 8'h3C);
    chk("R8 realigned rx count", rx_cnt - base, 1);
    chk("R8 realigned rx data", rx_log[base], 8'h6B);
    chk("R8 queue drained", q_empty, 1);
  endtask

  initial begin
    wait_clk(3);
    t_reset;
    rst_n = 1'b1;
    wait_clk(3);
    t_modes;
    t_early_msb;
    t_underflow;
    t_abort;
    t_overflow;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule